// File: doc/BRIEF.md
# USB Endpoint Buffer Arming Controller

This block holds the two software-visible request registers that arm and disarm the transfer buffers of a four-endpoint USB device controller. A write to the arm register asks the descriptor-fetch engine to read a new transfer descriptor for an endpoint and set up its buffer. A write to the disarm register asks the engine to drop whatever buffer that endpoint has armed. Each request bit is held as a level towards the engine and is cleared by hardware when the engine returns a one-cycle completion pulse. The hardware re-arm path sets the same bits for a short time after a descriptor retires.

Internally every endpoint direction has one bit in an 8-entry vector. Bits 3..0 are the receive (OUT) directions of endpoints 3..0, and bits 7..4 are the transmit (IN) directions. In the 32-bit registers the receive direction of endpoint n sits at bit n and the transmit direction sits at bit 16+n. The arm register is at word address 0 and the disarm register is at word address 1. A disarm request is held back from the engine while a packet is in flight on that direction, so the packet finishes first. The block also keeps a per-direction armed-status vector.

Top module: `ep_arm_ctrl`

## Requirements
- R1: After reset, both registers read zero and `prime_req`, `flush_req` and `primed` are all zero.
- R2: A write to word address 0 with a one at bit n (receive, endpoint n) or at bit 16+n (transmit, endpoint n) sets that arm bit. From the next cycle the register reads it back.
- R3: Zero bits in a write leave the stored bits unchanged. Writes to bits 31..20 and 15..4 are ignored, and those bits always read zero.
- R4: `prime_req` mirrors the arm register, vector bit n for the receive direction and bit 4+n for the transmit direction. A `prime_done` pulse on a direction clears its bit on the next cycle.
- R5: If a software write-one and a `prime_done` pulse hit the same bit in the same cycle, the bit stays set.
- R6: A one-cycle `reprime_set` pulse sets the matching arm bit, and it stays set until `prime_done` clears it.
- R7: A write with a one at the mapped position to word address 1 sets that disarm bit. `flush_req` for a direction is driven only while its `pkt_active` is low.
- R8: A `flush_done` pulse clears the matching disarm bit on the next cycle.
- R9: `primed` bits are set by `prime_done` and cleared by `flush_done`. When both arrive for one direction in the same cycle, the bit ends up clear.
- R10: Reads have no side effects, and reads of any word address other than 0 or 1 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the access |
| reprime_set | input | 8 | Hardware re-arm pulse per direction |
| prime_req | output | 8 | Arm request per direction to the descriptor engine |
| prime_done | input | 8 | Arm completion pulse per direction |
| flush_req | output | 8 | Disarm request per direction to the descriptor engine |
| flush_done | input | 8 | Disarm completion pulse per direction |
| pkt_active | input | 8 | Packet in flight per direction |
| primed | output | 8 | Armed buffer status per direction |

## Verification
Four behaviours are checked on every cycle: completion pulses clear requests, re-arm pulses set them, a disarm request is never driven while a packet is in flight, and armed status follows both completion pulses with disarm taking priority. The reserved fields of the read data are also checked every cycle. Only the bench scenarios can show the bit mapping between register positions and directions, the survival of a bit set in the same cycle as its clear, the release of a disarm request after its packet ends, and read data free of side effects on every address.

// File: rtl/ep_arm_pkg.sv
package ep_arm_pkg;
    localparam int REG_W  = 32;
    localparam int TX_LSB = 16;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_PRIME = 2'd1,
        SEL_FLUSH = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/ep_bus_decode.sv
module ep_bus_decode
    import ep_arm_pkg::*;
#(
    parameter int NUM_EP      = 4,
    parameter int ADDR_W      = 4,
    parameter int PRIME_WADDR = 0,
    parameter int FLUSH_WADDR = 1
) (
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    input  logic [2*NUM_EP-1:0] prime_bits,
    input  logic [2*NUM_EP-1:0] flush_bits,
    output logic [2*NUM_EP-1:0] prime_wset,
    output logic [2*NUM_EP-1:0] flush_wset,
    output logic [REG_W-1:0]    bus_rdata
);
    reg_sel_e sel;
    logic     wr_prime;
    logic     wr_flush;

    always_comb begin
        if (bus_addr == ADDR_W'(PRIME_WADDR))      sel = SEL_PRIME;
        else if (bus_addr == ADDR_W'(FLUSH_WADDR)) sel = SEL_FLUSH;
        else                                       sel = SEL_NONE;
    end

    assign wr_prime = bus_en && bus_we && (sel == SEL_PRIME);
    assign wr_flush = bus_en && bus_we && (sel == SEL_FLUSH);

    for (genvar n = 0; n < NUM_EP; n++) begin : g_map
        assign prime_wset[n]        = wr_prime & bus_wdata[n];
        assign prime_wset[NUM_EP+n] = wr_prime & bus_wdata[TX_LSB+n];
        assign flush_wset[n]        = wr_flush & bus_wdata[n];
        assign flush_wset[NUM_EP+n] = wr_flush & bus_wdata[TX_LSB+n];
    end

    always_comb begin
        logic [2*NUM_EP-1:0] src;
        bus_rdata = '0;
        case (sel)
            SEL_PRIME: src = prime_bits;
            SEL_FLUSH: src = flush_bits;
            default:   src = '0;
        endcase
        for (int n = 0; n < NUM_EP; n++) begin
            bus_rdata[n]        = src[n];
            bus_rdata[TX_LSB+n] = src[NUM_EP+n];
        end
    end
endmodule

// File: rtl/ep_req_bank.sv
module ep_req_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] req_o
);
    typedef struct packed {
        logic [WIDTH-1:0] req;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = (st_q.req & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;
endmodule

// File: rtl/ep_primed_track.sv
module ep_primed_track #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] arm_done_i,
    input  logic [WIDTH-1:0] disarm_done_i,
    output logic [WIDTH-1:0] primed_o
);
    typedef struct packed {
        logic [WIDTH-1:0] armed;
    } track_t;

    track_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.armed = (st_q.armed | arm_done_i) & ~disarm_done_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign primed_o = st_q.armed;
endmodule

// File: rtl/ep_arm_ctrl.sv
module ep_arm_ctrl
    import ep_arm_pkg::*;
#(
    parameter int NUM_EP      = 4,
    parameter int ADDR_W      = 4,
    parameter int PRIME_WADDR = 0,
    parameter int FLUSH_WADDR = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [2*NUM_EP-1:0] reprime_set,
    output logic [2*NUM_EP-1:0] prime_req,
    input  logic [2*NUM_EP-1:0] prime_done,
    output logic [2*NUM_EP-1:0] flush_req,
    input  logic [2*NUM_EP-1:0] flush_done,
    input  logic [2*NUM_EP-1:0] pkt_active,
    output logic [2*NUM_EP-1:0] primed
);
    localparam int VEC_W = 2 * NUM_EP;

    logic [VEC_W-1:0] prime_wset;
    logic [VEC_W-1:0] flush_wset;
    logic [VEC_W-1:0] prime_bits;
    logic [VEC_W-1:0] flush_bits;

    ep_bus_decode #(
        .NUM_EP     (NUM_EP),
        .ADDR_W     (ADDR_W),
        .PRIME_WADDR(PRIME_WADDR),
        .FLUSH_WADDR(FLUSH_WADDR)
    ) i_decode (
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .prime_bits(prime_bits),
        .flush_bits(flush_bits),
        .prime_wset(prime_wset),
        .flush_wset(flush_wset),
        .bus_rdata (bus_rdata)
    );

    ep_req_bank #(.WIDTH(VEC_W)) i_prime_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(prime_wset | reprime_set),
        .clr_i(prime_done),
        .req_o(prime_bits)
    );

    ep_req_bank #(.WIDTH(VEC_W)) i_flush_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(flush_wset),
        .clr_i(flush_done),
        .req_o(flush_bits)
    );

    ep_primed_track #(.WIDTH(VEC_W)) i_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_done_i   (prime_done),
        .disarm_done_i(flush_done),
        .primed_o     (primed)
    );

    assign prime_req = prime_bits;
    assign flush_req = flush_bits & ~pkt_active;
endmodule

// File: rtl/ep_arm_ctrl_chk.sv
module ep_arm_ctrl_chk #(
    parameter int NUM_EP      = 4,
    parameter int ADDR_W      = 4,
    parameter int PRIME_WADDR = 0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_en,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_rdata,
    input logic [2*NUM_EP-1:0] reprime_set,
    input logic [2*NUM_EP-1:0] prime_req,
    input logic [2*NUM_EP-1:0] prime_done,
    input logic [2*NUM_EP-1:0] flush_req,
    input logic [2*NUM_EP-1:0] flush_done,
    input logic [2*NUM_EP-1:0] pkt_active,
    input logic [2*NUM_EP-1:0] primed
);
    localparam logic [31:0] LIVE_MASK =
        ((32'd1 << NUM_EP) - 32'd1) | (((32'd1 << NUM_EP) - 32'd1) << 16);

    logic prime_wr;
    assign prime_wr = bus_en && bus_we && (bus_addr == ADDR_W'(PRIME_WADDR));

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~LIVE_MASK) == 32'd0);

    assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!prime_wr && ((prime_req & prime_done & ~reprime_set) != '0))
        |=> ((prime_req & $past(prime_req & prime_done & ~reprime_set)) == '0));

    assert_reprime_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reprime_set != '0)
        |=> ((prime_req & $past(reprime_set)) == $past(reprime_set)));

    assert_flush_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req & pkt_active) == '0);

    assert_flush_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_done != '0) |=> ((primed & $past(flush_done)) == '0));

    assert_prime_arms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((prime_done & ~flush_done) != '0)
        |=> ((primed & $past(prime_done & ~flush_done)) == $past(prime_done & ~flush_done)));
endmodule

bind ep_arm_ctrl ep_arm_ctrl_chk #(
    .NUM_EP     (NUM_EP),
    .ADDR_W     (ADDR_W),
    .PRIME_WADDR(PRIME_WADDR)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .reprime_set(reprime_set),
    .prime_req  (prime_req),
    .prime_done (prime_done),
    .flush_req  (flush_req),
    .flush_done (flush_done),
    .pkt_active (pkt_active),
    .primed     (primed)
);

// File: tb/test_ep_arm_ctrl.sv
`timescale 1ns/1ps
module test_ep_arm_ctrl;
    localparam int NEP = 4;
    localparam int VW  = 2 * NEP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [VW-1:0] reprime_set = '0;
    logic [VW-1:0] prime_req;
    logic [VW-1:0] prime_done = '0;
    logic [VW-1:0] flush_req;
    logic [VW-1:0] flush_done = '0;
    logic [VW-1:0] pkt_active = '0;
    logic [VW-1:0] primed;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ep_arm_ctrl i_ep_arm_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .reprime_set(reprime_set), .prime_req(prime_req), .prime_done(prime_done),
        .flush_req(flush_req), .flush_done(flush_done), .pkt_active(pkt_active),
        .primed(primed)
    );

    function automatic logic [31:0] reg_pos(int idx);
        return (idx < NEP) ? (32'd1 << idx) : (32'd1 << (16 + idx - NEP));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic pulse(ref logic [VW-1:0] sig, input logic [VW-1:0] m);
        @(negedge clk); sig = m;
        @(negedge clk); sig = '0;
    endtask

    initial begin
        int cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, r2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 prime_req", 32'(prime_req), 0);
        check("R1 flush_req", 32'(flush_req), 0);
        check("R1 primed", 32'(primed), 0);
        rst_n = 1'b1;
        rd(4'd0, r); check("R1 arm reg", r, 0);
        rd(4'd1, r); check("R1 disarm reg", r, 0);

        // R2 R4 R9: sweep every direction through arm and completion
        for (int i = 0; i < VW; i++) begin
            wr(4'd0, reg_pos(i));
            rd(4'd0, r);
            check("R2 arm readback", r, reg_pos(i));
            check("R4 prime_req mirror", 32'(prime_req), 32'd1 << i);
            pulse(prime_done, VW'(1) << i);
            check("R4 cleared by done", 32'(prime_req), 0);
            rd(4'd0, r);
            check("R4 arm reg cleared", r, 0);
            check("R9 primed set", 32'(primed), (32'd1 << (i + 1)) - 1);
        end

        // R3 zero and reserved writes
        wr(4'd0, 32'h0001_0001);
        wr(4'd0, 32'h0000_0000);
        rd(4'd0, r); check("R3 zero write keeps", r, 32'h0001_0001);
        wr(4'd0, 32'hFFF0_FFF0);
        rd(4'd0, r); check("R3 reserved ignored", r, 32'h0001_0001);
        check("R3 prime_req untouched", 32'(prime_req), 32'h11);

        // R10 reads free of side effects, unmapped addresses zero
        rd(4'd0, r); @(negedge clk); rd(4'd0, r2);
        check("R10 repeat read", r2, r);
        for (int a = 2; a < 16; a++) begin
            rd(4'(a), r); check("R10 unmapped read", r, 0);
        end

        // R5 set and clear in the same cycle
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h0000_0001;
        prime_done = 8'h01;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0; prime_done = '0;
        check("R5 set wins", 32'(prime_req), 32'h11);
        pulse(prime_done, 8'h11);
        check("R5 later clear", 32'(prime_req), 0);

        // R6 hardware re-arm
        for (int i = 0; i < VW; i++) begin
            pulse(reprime_set, VW'(1) << i);
            check("R6 re-arm set", 32'(prime_req), 32'd1 << i);
            @(negedge clk);
            check("R6 re-arm held", 32'(prime_req), 32'd1 << i);
            pulse(prime_done, VW'(1) << i);
            check("R6 re-arm cleared", 32'(prime_req), 0);
        end

        // R7 R8 R9: disarm each direction with a packet in flight
        for (int i = 0; i < VW; i++) begin
            pkt_active = VW'(1) << i;
            wr(4'd1, reg_pos(i));
            rd(4'd1, r); check("R7 disarm readback", r, reg_pos(i));
            check("R7 held while busy", 32'(flush_req), 0);
            @(negedge clk);
            check("R7 still held", 32'(flush_req), 0);
            pkt_active = '0;
            #0.5;
            check("R7 released", 32'(flush_req), 32'd1 << i);
            pulse(flush_done, VW'(1) << i);
            check("R8 cleared by done", 32'(flush_req), 0);
            rd(4'd1, r); check("R8 disarm reg cleared", r, 0);
            check("R9 primed dropped", 32'(primed), 32'hFF & ~((32'd2 << i) - 1));
        end

        // R9 disarm wins over arm in the same cycle
        @(negedge clk);
        prime_done = 8'h0F; flush_done = 8'h03;
        @(negedge clk);
        prime_done = '0; flush_done = '0;
        check("R9 flush wins", 32'(primed), 32'h0C);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule